// File: doc/BRIEF.md
# Quasi-Bidirectional I/O Expander Register Core

This block is the register core of an eight-pin I/O expander that sits behind a serial bus front end. It holds an output latch, a polarity-inversion mask and a direction mask, and it keeps a registered copy of the resolved pin levels. Each pin behaves as open-drain with a pull-up. A pin is pulled low only when both its direction bit and its output bit are 0. In every other case the pin floats high, unless an outside agent pulls it low.

The bus front end reaches the registers through a byte-wide port. The port has a 2-bit register index, a write strobe, write data and combinational read data. Outside agents signal a pull-down on each pin through an asynchronous input, which is synchronized inside the block. The resolved levels are published on a per-pin output. A bit of that output moves only when the resolved level of its pin moves: it goes to 1 on a rise and to 0 on a fall.

Top module: `gpio_xpndr_core`

## Requirements
- R1: After reset, the output latch reads 0xFF, the polarity mask reads 0x00, the direction mask reads 0xFF, and the input register and `pin_level_o` read 0xFF.
- R2: A write to index 1 (output latch), 2 (polarity) or 3 (direction) is read back unchanged at that index from the next cycle.
- R3: A pin whose output bit and direction bit are both 0 resolves to 0, whatever its external input is.
- R4: A pin whose output bit or direction bit is 1 resolves to the level of its external input: 1 means released, 0 means pulled low.
- R5: A read of index 0 returns the resolved pin levels XORed bitwise with the polarity mask.
- R6: A write to index 0 changes no register and no resolved level.
- R7: A write to the output latch or the direction mask is reflected in the resolved levels one clock after the write edge. An external input change is reflected three clock edges after it is applied: two synchronizer stages plus the level register.
- R8: A bit of `pin_level_o` changes only when the resolved level of that pin changes. Writing the polarity mask never moves `pin_level_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_idx_i | input | 2 | Register index: 0 input, 1 output, 2 polarity, 3 direction |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for reg_idx_i, combinational |
| ext_pin_i | input | 8 | Asynchronous external level per pin, 0 = pulled low |
| pin_level_o | output | 8 | Registered resolved level per pin |

## Verification
A corrupted output latch or direction mask shows up in two places. Its readback is wrong in the cycle after the write, and `pin_level_o` is wrong one clock later for every pin whose drive decision flips. A wrong synchronizer depth or reset value moves the cycle in which an external pull-down first appears, so a check sampled after exactly three edges catches it. A polarity mask that leaks into resolution moves `pin_level_o` on a polarity write, which should never happen. A polarity mask that is not applied on read shows only at index 0.

// File: rtl/xp_pkg.sv
package xp_pkg;
  localparam int unsigned IDX_W = 2;
  typedef enum logic [IDX_W-1:0] {
    IDX_IN  = 2'd0,
    IDX_OUT = 2'd1,
    IDX_POL = 2'd2,
    IDX_CFG = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/xp_sync.sv
module xp_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_V  = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_V}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/xp_regfile.sv
module xp_regfile
  import xp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wr_en_i,
  input  logic [W-1:0]     wr_data_i,
  output logic [W-1:0]     out_o,
  output logic [W-1:0]     pol_o,
  output logic [W-1:0]     cfg_o
);
  logic [W-1:0] out_q, pol_q, cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '1;
      pol_q <= '0;
      cfg_q <= '1;
    end else if (wr_en_i) begin
      unique case (reg_idx_e'(idx_i))
        IDX_OUT: out_q <= wr_data_i;
        IDX_POL: pol_q <= wr_data_i;
        IDX_CFG: cfg_q <= wr_data_i;
        default: ;  // input register is read-only
      endcase
    end
  end

  assign out_o = out_q;
  assign pol_o = pol_q;
  assign cfg_o = cfg_q;
endmodule

// File: rtl/xp_resolve.sv
module xp_resolve #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] out_i,
  input  logic [W-1:0] cfg_i,
  input  logic [W-1:0] ext_i,
  output logic [W-1:0] lvl_o
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    logic hiz, nxt, lvl_q;
    assign hiz = out_i[p] | cfg_i[p];
    // floating pin follows pull-up unless pulled low outside
    assign nxt = hiz & ext_i[p];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           lvl_q <= 1'b1;
      else if (nxt != lvl_q) lvl_q <= nxt;
    end
    assign lvl_o[p] = lvl_q;
  end
endmodule

// File: rtl/gpio_xpndr_core.sv
module gpio_xpndr_core
  import xp_pkg::*;
#(
  parameter int unsigned PINS        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] reg_idx_i,
  input  logic             wr_en_i,
  input  logic [PINS-1:0]  wr_data_i,
  output logic [PINS-1:0]  rd_data_o,
  input  logic [PINS-1:0]  ext_pin_i,
  output logic [PINS-1:0]  pin_level_o
);
  logic [PINS-1:0] out_q, pol_q, cfg_q, ext_s, lvl_q;

  xp_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_V(1'b1)) i_sync (
    .clk_i, .rst_ni, .d_i(ext_pin_i), .q_o(ext_s)
  );

  xp_regfile #(.W(PINS)) i_regs (
    .clk_i, .rst_ni, .idx_i(reg_idx_i), .wr_en_i, .wr_data_i,
    .out_o(out_q), .pol_o(pol_q), .cfg_o(cfg_q)
  );

  xp_resolve #(.W(PINS)) i_res (
    .clk_i, .rst_ni, .out_i(out_q), .cfg_i(cfg_q), .ext_i(ext_s), .lvl_o(lvl_q)
  );

  always_comb begin
    unique case (reg_idx_e'(reg_idx_i))
      IDX_IN:  rd_data_o = lvl_q ^ pol_q;
      IDX_OUT: rd_data_o = out_q;
      IDX_POL: rd_data_o = pol_q;
      default: rd_data_o = cfg_q;
    endcase
  end

  assign pin_level_o = lvl_q;
endmodule

// File: rtl/xp_chk.sv
module xp_chk #(
  parameter int unsigned PINS = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      reg_idx_i,
  input logic            wr_en_i,
  input logic [PINS-1:0] wr_data_i,
  input logic [PINS-1:0] rd_data_o,
  input logic [PINS-1:0] pin_level_o,
  input logic [PINS-1:0] out_q,
  input logic [PINS-1:0] pol_q,
  input logic [PINS-1:0] cfg_q,
  input logic [PINS-1:0] ext_s
);
  // R2
  out_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_idx_i == 2'd1) |=> (out_q == $past(wr_data_i)));
  // R3
  drive_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pin_level_o & ~$past(out_q | cfg_q)) == '0));
  // R4
  float_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pin_level_o == $past((out_q | cfg_q) & ext_s)));
  // R5
  rd_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_idx_i == 2'd0) |-> (rd_data_o == (pin_level_o ^ pol_q)));
  // R6
  in_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_idx_i == 2'd0) |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));
endmodule

bind gpio_xpndr_core xp_chk #(.PINS(PINS)) i_xp_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_idx_i(reg_idx_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .pin_level_o(pin_level_o),
  .out_q(out_q), .pol_q(pol_q), .cfg_q(cfg_q), .ext_s(ext_s)
);

// File: tb/test_gpio_xpndr_core.sv
module test_gpio_xpndr_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] idx = 2'd0;
  logic       we = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic [7:0] ext = 8'hFF;
  logic [7:0] lvl;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_xpndr_core i_gpio_xpndr_core (
    .clk_i(clk), .rst_ni(rst_n), .reg_idx_i(idx), .wr_en_i(we),
    .wr_data_i(wd), .rd_data_o(rd), .ext_pin_i(ext), .pin_level_o(lvl)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] i, input logic [7:0] d);
    idx = i; wd = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [1:0] i, input logic [7:0] exp);
    idx = i;
    #1;
    chk(req, rd, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] o, c, e, p, exp_l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdchk("R1", 2'd1, 8'hFF);
    rdchk("R1", 2'd2, 8'h00);
    rdchk("R1", 2'd3, 8'hFF);
    rdchk("R1", 2'd0, 8'hFF);
    chk("R1", lvl, 8'hFF);

    // R2 readback sweep
    for (int v = 0; v < 256; v++) begin
      wr(2'd2, 8'(v));
      rdchk("R2", 2'd2, 8'(v));
    end
    wr(2'd2, 8'h00);

    // R3 R4 near-exhaustive sweep of drive and external patterns
    for (int v = 0; v < 256; v++) begin
      o = 8'(v);
      c = 8'(v * 37 + 11);
      e = 8'(v * 91 + 5);
      ext = e;
      wr(2'd1, o);
      wr(2'd3, c);
      repeat (4) @(negedge clk);
      rdchk("R2", 2'd1, o);
      rdchk("R2", 2'd3, c);
      exp_l = (o | c) & e;
      chk("R3 R4", lvl, exp_l);
      // R3 driven-low pins stay low regardless of external input
      chk("R3", lvl & ~(o | c), 8'h00);
    end

    // R5 R8 polarity sweep with fixed levels
    ext = 8'hFF;
    wr(2'd1, 8'hA5);
    wr(2'd3, 8'h0F);
    repeat (4) @(negedge clk);
    exp_l = 8'hAF;
    for (int q = 0; q < 256; q++) begin
      wr(2'd2, 8'(q));
      chk("R8", lvl, exp_l);
      rdchk("R5", 2'd0, exp_l ^ 8'(q));
    end
    wr(2'd2, 8'h00);

    // R6 write to input index ignored
    wr(2'd0, 8'h00);
    @(negedge clk);
    chk("R6", lvl, exp_l);
    rdchk("R6", 2'd1, 8'hA5);
    rdchk("R6", 2'd2, 8'h00);
    rdchk("R6", 2'd3, 8'h0F);
    rdchk("R6", 2'd0, exp_l);

    // R7 write-to-level latency: one clock after the write edge
    idx = 2'd3; wd = 8'h00; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    chk("R7", lvl, exp_l);
    @(negedge clk);
    chk("R7", lvl, 8'hA5);

    // R7 external latency: three edges
    wr(2'd3, 8'hFF);
    @(negedge clk);
    chk("R7", lvl, 8'hFF);
    ext = 8'h3C;
    @(negedge clk);
    chk("R7", lvl, 8'hFF);
    @(negedge clk);
    chk("R7", lvl, 8'hFF);
    @(negedge clk);
    chk("R7", lvl, 8'h3C);

    // R8 output-latch change on a floating pin leaves the level unchanged
    wr(2'd1, 8'h00);
    @(negedge clk);
    chk("R8", lvl, 8'h3C);
    ext = 8'hFF;
    repeat (4) @(negedge clk);
    chk("R8", lvl, 8'hFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule